// File: doc/BRIEF.md
# Sector Load Buffer and Program Sequencer

This block gathers byte writes into a one-sector page buffer once an external unlock decoder has armed programming. The first accepted write opens a load window. That write selects the sector, and it presets every buffer byte to FFh except the byte it carries. Later writes to the same sector may arrive in any order. Each one restarts an inactivity timer. When the timer runs out with no new write, the window closes without any commit command. The block then runs a timed cycle on a synchronous internal array: the target sector is erased first, and then the whole buffer is written into it in one operation.

A microsecond tick paces every interval: the power-on hold, the load window, the erase phase and the program phase. Each length is a parameter, so a simulation can shorten it. The block raises `busy` during the power-on hold and during the erase and program phases. When a program cycle completes it pulses `cycleDone` for one cycle, which re-locks the unlock decoder. It also reports the address and data of the last accepted byte. A registered read port returns array contents one cycle after the address is presented.

Top module: `secprog_top`

## Requirements
- R1: A byte address has two fields. Bits 14..6 pick one of 512 sectors, and bits 5..0 pick the byte inside that sector. After a program cycle, each loaded byte reads back at exactly the address it was written to.
- R2: Bytes of one window may be loaded in any order, for example descending, and all of them are programmed.
- R3: A same-sector write that arrives within LOAD_WIN_US ticks of the previous accepted write is accepted and restarts the window. The arrival limit is the LOAD_WIN_US-th tick itself. If LOAD_WIN_US ticks pass with no such write, `busy` rises on that tick.
- R4: After a program cycle, every byte of the sector that was not loaded in the window reads FFh.
- R5: The sector keeps its old contents until the erase phase ends. From then until the cycle ends, every byte of the sector reads FFh.
- R6: `busy` stays high for exactly ERASE_US+PROG_US ticks. In the cycle in which it falls, `cycleDone` is high for that one cycle only.
- R7: Inside an open window, a write whose sector field differs from the window's sector is ignored. It changes neither `lastAddr`/`lastData` nor the programmed data.
- R8: A write strobe is ignored while `busy` is high. With no window open, a write strobe is also ignored unless `armed` is high.
- R9: `lastAddr` and `lastData` hold the address and data of the most recently accepted write, and they keep those values through the program cycle.
- R10: Reset sets `lastAddr` and `lastData` to 0 and `cycleDone` to 0. After reset, `busy` stays high for POWERON_US ticks, and every write strobe in that interval is ignored.
- R11: When one byte is written twice in a window, the later value is the one programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-cycle pulse each microsecond |
| armed | input | 1 | Programming unlocked by the command decoder |
| wrStrobe | input | 1 | One-cycle pulse for a captured byte write |
| wrAddr | input | 15 | Captured write address (sector field above byte field) |
| wrData | input | 8 | Captured write data |
| rdAddr | input | 15 | Array read address |
| rdData | output | 8 | Array read data, registered one cycle after rdAddr |
| busy | output | 1 | High during power-on hold, erase and program |
| cycleDone | output | 1 | One-cycle pulse at the end of a program cycle |
| lastAddr | output | 15 | Address of the last accepted byte |
| lastData | output | 8 | Data of the last accepted byte |

## Verification
Two situations are hard to reach from the ports. The first is a write that lands on the very tick that would close the window. The second is the short interval in which the sector is already erased but not yet programmed. With the tick held high every cycle, the bench counts cycles from the edge that samples a write. It places the next write on the window's last tick, and it checks that `busy` rises exactly one window later. While `busy` is high, it issues array reads at computed offsets: one before the erase phase ends, which must return the old contents, and one after it, which must return FFh. A write during `busy` and a write to a foreign sector are then traced through `lastAddr` and through read-back of the sector.

// File: rtl/secprog_pkg.sv
package secprog_pkg;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_IDLE,
    ST_LOAD,
    ST_ERASE,
    ST_PROG
  } secprog_state_t;

  typedef struct packed {
    logic startWin;
    logic loadByte;
    logic eraseRow;
    logic commitRow;
  } secprog_strb_t;

endpackage

// File: rtl/secprog_ctrl.sv
module secprog_ctrl
  import secprog_pkg::*;
#(
  parameter int LOAD_WIN_US = 150,
  parameter int ERASE_US    = 10000,
  parameter int PROG_US     = 10000,
  parameter int POWERON_US  = 10000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          usTick,
  input  logic          armed,
  input  logic          wrStrobe,
  input  logic          sectorMatch,
  output secprog_strb_t strb,
  output logic          busy,
  output logic          cycleDone
);

  localparam int MAX_A  = (LOAD_WIN_US > ERASE_US) ? LOAD_WIN_US : ERASE_US;
  localparam int MAX_B  = (PROG_US > POWERON_US) ? PROG_US : POWERON_US;
  localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TIMER_W = $clog2(MAX_US + 1);

  secprog_state_t stateQ;
  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W-1:0] limitSel;
  logic acceptLoad;
  logic lastTick;
  logic doneQ;

  // terminal count of the interval that the current state times
  always_comb begin
    unique case (stateQ)
      ST_POWER: limitSel = TIMER_W'(POWERON_US - 1);
      ST_LOAD:  limitSel = TIMER_W'(LOAD_WIN_US - 1);
      ST_ERASE: limitSel = TIMER_W'(ERASE_US - 1);
      ST_PROG:  limitSel = TIMER_W'(PROG_US - 1);
      default:  limitSel = '0;
    endcase
  end

  always_comb begin
    // R7/R8: a write counts only when idle and armed, or inside a window on the same sector
    acceptLoad     = wrStrobe && ((stateQ == ST_IDLE && armed) ||
                                  (stateQ == ST_LOAD && sectorMatch));
    lastTick       = usTick && (timerQ == limitSel);
    strb.startWin  = acceptLoad && (stateQ == ST_IDLE);
    strb.loadByte  = acceptLoad;
    strb.eraseRow  = (stateQ == ST_ERASE) && lastTick;
    strb.commitRow = (stateQ == ST_PROG) && lastTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_POWER;
      timerQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.commitRow;
      unique case (stateQ)
        ST_POWER: begin
          if (lastTick) begin
            stateQ <= ST_IDLE;
            timerQ <= '0;
          end else if (usTick) begin
            timerQ <= timerQ + 1'b1;
          end
        end
        ST_IDLE: begin
          if (acceptLoad) begin
            stateQ <= ST_LOAD;
            timerQ <= '0;
          end
        end
        ST_LOAD: begin
          // R3: an accepted write on the final tick still extends the window
          if (acceptLoad) begin
            timerQ <= '0;
          end else if (lastTick) begin
            stateQ <= ST_ERASE;
            timerQ <= '0;
          end else if (usTick) begin
            timerQ <= timerQ + 1'b1;
          end
        end
        ST_ERASE: begin
          if (lastTick) begin
            stateQ <= ST_PROG;
            timerQ <= '0;
          end else if (usTick) begin
            timerQ <= timerQ + 1'b1;
          end
        end
        ST_PROG: begin
          if (lastTick) begin
            stateQ <= ST_IDLE;
            timerQ <= '0;
          end else if (usTick) begin
            timerQ <= timerQ + 1'b1;
          end
        end
        default: begin
          stateQ <= ST_IDLE;
          timerQ <= '0;
        end
      endcase
    end
  end

  assign busy      = (stateQ == ST_POWER) || (stateQ == ST_ERASE) || (stateQ == ST_PROG);
  assign cycleDone = doneQ;

endmodule

// File: rtl/secprog_data.sv
module secprog_data
  import secprog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BYTE_BITS   = 6,
  parameter int SECTOR_BITS = 9
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  secprog_strb_t                    strb,
  input  logic [SECTOR_BITS+BYTE_BITS-1:0] wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [SECTOR_BITS+BYTE_BITS-1:0] rdAddr,
  output logic [DATA_W-1:0]                rdData,
  output logic                             sectorMatch,
  output logic [SECTOR_BITS+BYTE_BITS-1:0] lastAddr,
  output logic [DATA_W-1:0]                lastData
);

  localparam int ADDR_W       = SECTOR_BITS + BYTE_BITS;
  localparam int SECTOR_BYTES = 1 << BYTE_BITS;
  localparam int NUM_SECTORS  = 1 << SECTOR_BITS;
  localparam int ROW_W        = DATA_W * SECTOR_BYTES;

  logic [SECTOR_BITS-1:0] secQ;
  logic [SECTOR_BITS-1:0] wrSec;
  logic [BYTE_BITS-1:0]   wrByte;
  logic [SECTOR_BITS-1:0] rdSec;
  logic [BYTE_BITS-1:0]   rdByte;
  logic [ROW_W-1:0]       rowFlat;
  logic [ROW_W-1:0]       memArr [NUM_SECTORS];

  // R1: sector field above, byte field below
  assign wrSec  = wrAddr[ADDR_W-1:BYTE_BITS];
  assign wrByte = wrAddr[BYTE_BITS-1:0];
  assign rdSec  = rdAddr[ADDR_W-1:BYTE_BITS];
  assign rdByte = rdAddr[BYTE_BITS-1:0];
  assign sectorMatch = (wrSec == secQ);

  // page buffer, one register per byte slot
  for (genvar i = 0; i < SECTOR_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (strb.loadByte && wrByte == BYTE_BITS'(i)) begin
        slotQ <= wrData;
      end else if (strb.startWin) begin
        slotQ <= '1;
      end
    end
    assign rowFlat[i*DATA_W +: DATA_W] = slotQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ     <= '0;
      lastAddr <= '0;
      lastData <= '0;
    end else begin
      if (strb.startWin) begin
        secQ <= wrSec;
      end
      if (strb.loadByte) begin
        lastAddr <= wrAddr;
        lastData <= wrData;
      end
    end
  end

  // whole-row erase then whole-row program; registered read
  always_ff @(posedge clk) begin
    if (strb.eraseRow) begin
      memArr[secQ] <= '1;
    end else if (strb.commitRow) begin
      memArr[secQ] <= rowFlat;
    end
    rdData <= memArr[rdSec][rdByte*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/secprog_top.sv
module secprog_top
  import secprog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BYTE_BITS   = 6,
  parameter int SECTOR_BITS = 9,
  parameter int LOAD_WIN_US = 150,
  parameter int ERASE_US    = 10000,
  parameter int PROG_US     = 10000,
  parameter int POWERON_US  = 10000,
  localparam int ADDR_W     = SECTOR_BITS + BYTE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              armed,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              cycleDone,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [DATA_W-1:0] lastData
);

  secprog_strb_t strb;
  logic sectorMatch;

  secprog_ctrl #(
    .LOAD_WIN_US(LOAD_WIN_US),
    .ERASE_US   (ERASE_US),
    .PROG_US    (PROG_US),
    .POWERON_US (POWERON_US)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .usTick     (usTick),
    .armed      (armed),
    .wrStrobe   (wrStrobe),
    .sectorMatch(sectorMatch),
    .strb       (strb),
    .busy       (busy),
    .cycleDone  (cycleDone)
  );

  secprog_data #(
    .DATA_W     (DATA_W),
    .BYTE_BITS  (BYTE_BITS),
    .SECTOR_BITS(SECTOR_BITS)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .sectorMatch(sectorMatch),
    .lastAddr   (lastAddr),
    .lastData   (lastData)
  );

endmodule

// File: rtl/secprog_checker.sv
module secprog_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic              busy,
  input logic              cycleDone,
  input logic [ADDR_W-1:0] lastAddr,
  input logic [DATA_W-1:0] lastData
);

  // R8: nothing is accepted while busy
  p_busy_blocks_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(lastAddr) && $stable(lastData)));

  // R9: the reported byte changes only after a write strobe
  p_last_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastAddr) |-> $past(wrStrobe));

  // R6: completion pulse is a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R6: completion coincides with busy falling
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (!busy && $past(busy)));

endmodule

bind secprog_top secprog_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrStrobe (wrStrobe),
  .busy     (busy),
  .cycleDone(cycleDone),
  .lastAddr (lastAddr),
  .lastData (lastData)
);

// File: tb/tb_secprog_top.sv
module tb_secprog_top;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 30;
  localparam int E   = 20;
  localparam int P   = 40;
  localparam int PON = 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b1;
  logic        armed = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [14:0] rdAddr = '0;
  logic [7:0]  rdData;
  logic        busy;
  logic        cycleDone;
  logic [14:0] lastAddr;
  logic [7:0]  lastData;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secprog_top #(
    .LOAD_WIN_US(W),
    .ERASE_US   (E),
    .PROG_US    (P),
    .POWERON_US (PON)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .armed    (armed),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .busy     (busy),
    .cycleDone(cycleDone),
    .lastAddr (lastAddr),
    .lastData (lastData)
  );

  function automatic logic [14:0] mkAddr(input int sec, input int idx);
    return 15'((sec << 6) | idx);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadByte(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr   = a;
    wrData   = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic readByte(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    d = rdData;
  endtask

  // waits for busy, counts its length, checks the done pulse (R6)
  task automatic runCycle();
    int guard = 0;
    int cnt = 0;
    while (!busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    while (busy && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == E + P, "R6 busy length", cnt, E + P);
    check(cycleDone == 1'b1, "R6 done pulse high", cycleDone, 1);
    @(negedge clk);
    check(cycleDone == 1'b0, "R6 done pulse one cycle", cycleDone, 0);
  endtask

  task automatic testPowerUp();
    int cnt = 0;
    check(busy == 1'b1, "R10 busy at reset release", busy, 1);
    check(cycleDone == 1'b0, "R10 done at reset", cycleDone, 0);
    check(lastAddr == 15'd0 && lastData == 8'd0, "R10 last regs at reset", lastAddr, 0);
    armed = 1'b1;
    while (busy && cnt < 1000) begin
      if (cnt == 2) begin
        wrAddr = 15'h1234; wrData = 8'h5A; wrStrobe = 1'b1;
      end
      if (cnt == 3) wrStrobe = 1'b0;
      @(negedge clk);
      cnt++;
    end
    armed = 1'b0;
    check(cnt == PON, "R10 power-on hold length", cnt, PON);
    check(lastAddr == 15'd0, "R10 strobe during hold ignored", lastAddr, 0);
    repeat (W + 5) @(negedge clk);
    check(busy == 1'b0, "R10 no window from held strobe", busy, 0);
  endtask

  task automatic testFullSector();
    logic [7:0] d;
    armed = 1'b1;
    for (int i = 63; i >= 0; i--) begin
      loadByte(mkAddr(5, i), 8'(i) ^ 8'hA5);
      armed = 1'b0;
    end
    loadByte(mkAddr(5, 10), 8'h3C);
    check(lastAddr == mkAddr(5, 10), "R9 lastAddr", lastAddr, mkAddr(5, 10));
    check(lastData == 8'h3C, "R9 lastData", lastData, 8'h3C);
    runCycle();
    check(lastAddr == mkAddr(5, 10), "R9 lastAddr held after cycle", lastAddr, mkAddr(5, 10));
    for (int i = 0; i < 64; i++) begin
      readByte(mkAddr(5, i), d);
      if (i == 10)
        check(d == 8'h3C, "R11 later write wins", d, 8'h3C);
      else
        check(d == (8'(i) ^ 8'hA5), "R1 R2 byte placement any order", d, 8'(i) ^ 8'hA5);
    end
  endtask

  task automatic testPartial();
    logic [7:0] d;
    int cnt = 0;
    armed = 1'b1;
    loadByte(mkAddr(5, 3), 8'h77);
    armed = 1'b0;
    repeat (W - 2) @(negedge clk);
    check(busy == 1'b0, "R3 window still open", busy, 0);
    loadByte(mkAddr(5, 40), 8'h88);
    check(lastAddr == mkAddr(5, 40), "R3 load on last tick accepted", lastAddr, mkAddr(5, 40));
    repeat (W - 1) @(negedge clk);
    check(busy == 1'b0, "R3 window open one tick before close", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R3 busy on closing tick", busy, 1);
    while (busy && cnt < 1000) begin
      if (cnt == 2) check(rdData == 8'hA5, "R5 old data before erase", rdData, 8'hA5);
      if (cnt == E + 5) check(rdData == 8'hFF, "R5 erased during program", rdData, 8'hFF);
      if (cnt == 1 || cnt == E + 4) rdAddr = mkAddr(5, 0);
      @(negedge clk);
      cnt++;
    end
    check(cnt == E + P, "R6 busy length partial", cnt, E + P);
    for (int i = 0; i < 64; i++) begin
      readByte(mkAddr(5, i), d);
      if (i == 3)       check(d == 8'h77, "R4 loaded byte 3", d, 8'h77);
      else if (i == 40) check(d == 8'h88, "R4 loaded byte 40", d, 8'h88);
      else              check(d == 8'hFF, "R4 unloaded byte reads FF", d, 8'hFF);
    end
  endtask

  task automatic testIgnored();
    logic [7:0] d;
    int guard = 0;
    armed = 1'b0;
    loadByte(mkAddr(7, 1), 8'h42);
    check(lastAddr == mkAddr(5, 40), "R8 unarmed strobe ignored", lastAddr, mkAddr(5, 40));
    repeat (W + 5) @(negedge clk);
    check(busy == 1'b0, "R8 unarmed strobe opens no window", busy, 0);
    armed = 1'b1;
    loadByte(mkAddr(7, 1), 8'h42);
    armed = 1'b0;
    loadByte(mkAddr(9, 2), 8'h99);
    check(lastAddr == mkAddr(7, 1), "R7 foreign sector addr ignored", lastAddr, mkAddr(7, 1));
    check(lastData == 8'h42, "R7 foreign sector data ignored", lastData, 8'h42);
    while (!busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    armed = 1'b1;
    loadByte(mkAddr(7, 5), 8'h55);
    armed = 1'b0;
    check(lastAddr == mkAddr(7, 1), "R8 strobe while busy ignored", lastAddr, mkAddr(7, 1));
    guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    readByte(mkAddr(7, 1), d);
    check(d == 8'h42, "R7 window byte programmed", d, 8'h42);
    readByte(mkAddr(7, 2), d);
    check(d == 8'hFF, "R7 foreign byte not programmed", d, 8'hFF);
    readByte(mkAddr(7, 5), d);
    check(d == 8'hFF, "R8 busy byte not programmed", d, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testPowerUp();
    testFullSector();
    testPartial();
    testIgnored();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule